// File: doc/BRIEF.md
# Cascaded Up/Down Timer Pair

Two 16-bit up/down counters are chained into a 32-bit timer. The lower counter advances on a prescaled tick of the peripheral clock. Each time it wraps (0xFFFF to 0x0000 counting up, 0x0000 to 0xFFFF counting down), that wrap is the count clock of the upper counter. Each counter has a direction input. A two-phase register bus writes either counter, the compare values, the control word and the flag-clear mask. Each write is taken in a request cycle (T1) and committed in the following cycle (T2).

The lower and upper counters each compare against their own compare value and give registered one-cycle match pulses. The upper channel has a capture register B that can latch a free-running timestamp counter on an upper compare match. A bank of four auxiliary capture registers can latch the same timestamp on each effective upper count clock.

A T2 commit to the lower counter can fall in the cycle where the lower counter wraps. In that case the written value wins and the carry or borrow into the upper counter is dropped. The upper compare is still evaluated against the held upper value, so a match can still fire. The auxiliary captures do not fire.

Top module: `casc_timer_pair`

## Requirements
- R1: A write requested in cycle k (bus_req_i high) commits at the clock edge ending cycle k+1. Addresses: 0 lower count, 1 upper count, 2 lower compare, 3 upper compare, 4 control, 5 flag clear. Other addresses do nothing.
- R2: Control bits are: bit 0 run, bits 2:1 prescale select s, bit 3 auxiliary capture enable, bit 4 capture-B enable, bit 5 shared clear enable. A free-running 6-bit prescaler counts every cycle. With run set, the lower counter steps once in each cycle where the prescaler's low 2*s bits are all ones. It steps up, or down when lo_down_i is high.
- R3: A lower wrap with no lower write in that cycle steps the upper counter in the direction given by hi_down_i. Otherwise the upper counter holds, apart from writes and clears.
- R4: When a lower-counter commit coincides with a lower wrap, the written value is loaded and the upper counter keeps its value.
- R5: Lower match fires when the lower counter steps to its compare value with no lower write in that cycle. Upper match fires on every lower wrap, dropped carry included, when the resulting upper value equals its compare value and no upper write commits. Both appear as a one-cycle pulse in the cycle after the event.
- R6: With bit 3 set, each effective (not dropped) upper count clock latches the timestamp counter into all four auxiliary capture registers, packed A in bits 15:0 to D in bits 63:48. aux_cap_o pulses in the following cycle. A dropped carry captures nothing.
- R7: With bit 4 set, an upper match latches the timestamp into capture B, and hi_capb_o pulses together with hi_match_o.
- R8: With bit 5 set, a lower match clears both counters in the same edge, before either shows the compared value. A commit to a counter overrides the clear for that counter.
- R9: flags_o holds sticky bits: 0 lower match, 1 upper match, 2 capture B, 3 auxiliary capture. Each is set with its pulse. Writing ones to address 5 clears them, and a set in the same cycle wins.
- R10: A commit to the upper counter in a cycle where it would count loads the written value, and no upper match is evaluated in that cycle.
- R11: After reset, counters, control, flags, pulses, captures and the timestamp are zero, and both compare values are 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Write request (T1 phase) |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| lo_down_i | input | 1 | Lower counter counts down when high |
| hi_down_i | input | 1 | Upper counter counts down when high |
| lo_cnt_o | output | 16 | Lower counter value |
| hi_cnt_o | output | 16 | Upper counter value |
| lo_match_o | output | 1 | Lower compare match pulse |
| hi_match_o | output | 1 | Upper compare match pulse |
| hi_capb_o | output | 1 | Upper capture B pulse |
| hi_capb_val_o | output | 16 | Upper capture B value |
| aux_cap_o | output | 1 | Auxiliary capture pulse |
| aux_cap_val_o | output | 64 | Four auxiliary capture registers |
| aux_cnt_o | output | 16 | Free-running timestamp counter |
| flags_o | output | 4 | Sticky event flags |

## Verification
Some rules are checked by the assertions on every cycle. A lower commit lands exactly one edge after T2. A contending lower write freezes the upper counter and suppresses the auxiliary capture. The upper counter moves only on a wrap, write or clear. Capture B never pulses without an upper match, and a shared clear zeroes both halves together. Other behaviour only the bench's scenarios can show. That covers the exact cycle where the dropped-carry match fires against the held upper value, underflow contention when counting down, and an upper write beating its own count. It also covers prescale timing, the flag set-over-clear race and the timestamp values taken by the capture registers.

// File: rtl/casc_timer_pkg.sv
package casc_timer_pkg;
  localparam int NFLAG = 4;
  localparam int F_LO_MATCH = 0;
  localparam int F_HI_MATCH = 1;
  localparam int F_CAPB     = 2;
  localparam int F_AUX_CAP  = 3;

  typedef enum logic [2:0] {
    A_LO_CNT   = 3'd0,
    A_HI_CNT   = 3'd1,
    A_LO_CMP   = 3'd2,
    A_HI_CMP   = 3'd3,
    A_CTRL     = 3'd4,
    A_FLAG_CLR = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic       clr_en;
    logic       capb_en;
    logic       aux_en;
    logic [1:0] psc_sel;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int PSC_W = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] mask;

  always_comb mask = PSC_W'((32'd1 << (2 * sel_i)) - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && ((cnt_q & mask) == mask);
endmodule

// File: rtl/ct_updown_cnt.sv
module ct_updown_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic         down_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] step;
  logic         at_edge;

  always_comb begin
    step    = down_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
    at_edge = down_i ? (cnt_q == '0) : (cnt_q == '1);
    // value after load or count, before any clear
    val_o   = load_i ? load_val_i : (cnt_en_i ? step : cnt_q);
  end

  assign wrap_o = cnt_en_i && at_edge;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (clr_i)  cnt_q <= '0;
    else             cnt_q <= val_o;
  end
endmodule

// File: rtl/ct_capture_bank.sv
module ct_capture_bank #(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cap_i,
  input  logic [W-1:0]   din_i,
  output logic [N*W-1:0] dout_o
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q <= '0;
      else if (cap_i) q <= din_i;
    end
    assign dout_o[g*W +: W] = q;
  end
endmodule

// File: rtl/casc_timer_pair.sv
module casc_timer_pair
  import casc_timer_pkg::*;
#(
  parameter int CW    = 16,
  parameter int AW    = 3,
  parameter int PSC_W = 6,
  parameter int NAUX  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_req_i,
  input  logic [AW-1:0]        bus_addr_i,
  input  logic [CW-1:0]        bus_wdata_i,
  input  logic                 lo_down_i,
  input  logic                 hi_down_i,
  output logic [CW-1:0]        lo_cnt_o,
  output logic [CW-1:0]        hi_cnt_o,
  output logic                 lo_match_o,
  output logic                 hi_match_o,
  output logic                 hi_capb_o,
  output logic [CW-1:0]        hi_capb_val_o,
  output logic                 aux_cap_o,
  output logic [NAUX*CW-1:0]   aux_cap_val_o,
  output logic [CW-1:0]        aux_cnt_o,
  output logic [NFLAG-1:0]     flags_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  // T2 stage of the bus
  logic          t2_vld_q;
  logic [AW-1:0] t2_addr_q;
  logic [CW-1:0] t2_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t2_vld_q  <= 1'b0;
      t2_addr_q <= '0;
      t2_data_q <= '0;
    end else begin
      t2_vld_q  <= bus_req_i;
      t2_addr_q <= bus_addr_i;
      t2_data_q <= bus_wdata_i;
    end
  end

  logic lo_wr, hi_wr, lo_cmp_wr, hi_cmp_wr, ctrl_wr, fclr_wr;
  always_comb begin
    lo_wr     = t2_vld_q && (t2_addr_q == AW'(A_LO_CNT));
    hi_wr     = t2_vld_q && (t2_addr_q == AW'(A_HI_CNT));
    lo_cmp_wr = t2_vld_q && (t2_addr_q == AW'(A_LO_CMP));
    hi_cmp_wr = t2_vld_q && (t2_addr_q == AW'(A_HI_CMP));
    ctrl_wr   = t2_vld_q && (t2_addr_q == AW'(A_CTRL));
    fclr_wr   = t2_vld_q && (t2_addr_q == AW'(A_FLAG_CLR));
  end

  ctrl_t         ctrl_q;
  logic [CW-1:0] lo_cmp_q, hi_cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      lo_cmp_q <= '1;
      hi_cmp_q <= '1;
    end else begin
      if (ctrl_wr)   ctrl_q   <= ctrl_t'(t2_data_q[CTRL_W-1:0]);
      if (lo_cmp_wr) lo_cmp_q <= t2_data_q;
      if (hi_cmp_wr) hi_cmp_q <= t2_data_q;
    end
  end

  logic tick;
  ct_prescaler #(.PSC_W(PSC_W)) i_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q.run),
    .sel_i  (ctrl_q.psc_sel),
    .tick_o (tick)
  );

  logic [CW-1:0] lo_val, hi_val;
  logic          lo_wrap, hi_wrap, hi_clk, clr_both;
  logic          lo_match_evt, hi_match_evt, capb_evt, aux_evt;

  // lower counter: a bus commit wins over count and clear
  ct_updown_cnt #(.W(CW)) i_lo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_en_i   (tick),
    .down_i     (lo_down_i),
    .load_i     (lo_wr),
    .load_val_i (t2_data_q),
    .clr_i      (clr_both),
    .cnt_o      (lo_cnt_o),
    .val_o      (lo_val),
    .wrap_o     (lo_wrap)
  );

  // carry/borrow dropped when the lower counter is being written
  assign hi_clk = lo_wrap && !lo_wr;

  ct_updown_cnt #(.W(CW)) i_hi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_en_i   (hi_clk),
    .down_i     (hi_down_i),
    .load_i     (hi_wr),
    .load_val_i (t2_data_q),
    .clr_i      (clr_both),
    .cnt_o      (hi_cnt_o),
    .val_o      (hi_val),
    .wrap_o     (hi_wrap)
  );

  always_comb begin
    lo_match_evt = tick && !lo_wr && (lo_val == lo_cmp_q);
    clr_both     = ctrl_q.clr_en && lo_match_evt;
    // compare is evaluated on the raw wrap, against the held value if dropped
    hi_match_evt = lo_wrap && !hi_wr && (hi_val == hi_cmp_q);
    capb_evt     = ctrl_q.capb_en && hi_match_evt;
    aux_evt      = ctrl_q.aux_en && hi_clk;
  end

  logic [CW-1:0] aux_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) aux_q <= '0;
    else         aux_q <= aux_q + 1'b1;
  end
  assign aux_cnt_o = aux_q;

  ct_capture_bank #(.W(CW), .N(NAUX)) i_aux_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (aux_evt),
    .din_i  (aux_q),
    .dout_o (aux_cap_val_o)
  );

  ct_capture_bank #(.W(CW), .N(1)) i_capb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (capb_evt),
    .din_i  (aux_q),
    .dout_o (hi_capb_val_o)
  );

  logic [NFLAG-1:0] evt_vec, flags_q, clr_mask;
  always_comb begin
    evt_vec             = '0;
    evt_vec[F_LO_MATCH] = lo_match_evt;
    evt_vec[F_HI_MATCH] = hi_match_evt;
    evt_vec[F_CAPB]     = capb_evt;
    evt_vec[F_AUX_CAP]  = aux_evt;
    clr_mask            = fclr_wr ? t2_data_q[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q    <= '0;
      lo_match_o <= 1'b0;
      hi_match_o <= 1'b0;
      hi_capb_o  <= 1'b0;
      aux_cap_o  <= 1'b0;
    end else begin
      flags_q    <= (flags_q & ~clr_mask) | evt_vec;
      lo_match_o <= lo_match_evt;
      hi_match_o <= hi_match_evt;
      hi_capb_o  <= capb_evt;
      aux_cap_o  <= aux_evt;
    end
  end
  assign flags_o = flags_q;
endmodule

// File: rtl/casc_timer_pair_chk.sv
module casc_timer_pair_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] lo_cnt_o,
  input logic [CW-1:0] hi_cnt_o,
  input logic          hi_match_o,
  input logic          hi_capb_o,
  input logic          aux_cap_o,
  input logic [3:0]    flags_o,
  input logic          lo_wrap,
  input logic          hi_wrap,
  input logic          lo_wr,
  input logic          hi_wr,
  input logic          clr_both,
  input logic          hi_down_i,
  input logic [CW-1:0] t2_data_q
);
  p_lo_commit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr |=> lo_cnt_o == $past(t2_data_q));

  p_hi_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lo_wrap || hi_wr || clr_both) |=> $stable(hi_cnt_o));

  p_hi_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wrap && !hi_wr && !clr_both) |=> hi_cnt_o == ($past(hi_down_i) ? {CW{1'b1}} : {CW{1'b0}}));

  p_carry_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_wrap && lo_wr && !hi_wr && !clr_both) |=> $stable(hi_cnt_o));

  p_no_aux_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_wrap && lo_wr) |=> !aux_cap_o);

  p_capb_needs_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_capb_o |-> hi_match_o);

  p_clear_both_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_both && !hi_wr) |=> (lo_cnt_o == '0 && hi_cnt_o == '0));

  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_match_o |-> flags_o[1]);
endmodule

bind casc_timer_pair casc_timer_pair_chk #(.CW(CW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lo_cnt_o   (lo_cnt_o),
  .hi_cnt_o   (hi_cnt_o),
  .hi_match_o (hi_match_o),
  .hi_capb_o  (hi_capb_o),
  .aux_cap_o  (aux_cap_o),
  .flags_o    (flags_o),
  .lo_wrap    (lo_wrap),
  .hi_wrap    (hi_wrap),
  .lo_wr      (lo_wr),
  .hi_wr      (hi_wr),
  .clr_both   (clr_both),
  .hi_down_i  (hi_down_i),
  .t2_data_q  (t2_data_q)
);

// File: tb/test_casc_timer_pair.sv
module test_casc_timer_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        lo_down = 1'b0;
  logic        hi_down = 1'b0;
  logic [15:0] lo_cnt, hi_cnt, capb_val, aux_cnt;
  logic        lo_m, hi_m, capb, auxc;
  logic [63:0] aux_val;
  logic [3:0]  flags;

  int n_tests = 0;
  int n_fail  = 0;
  bit cmp_en  = 1'b0;

  always #5 clk = ~clk;

  casc_timer_pair i_casc_timer_pair (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .lo_down_i(lo_down), .hi_down_i(hi_down),
    .lo_cnt_o(lo_cnt), .hi_cnt_o(hi_cnt), .lo_match_o(lo_m), .hi_match_o(hi_m),
    .hi_capb_o(capb), .hi_capb_val_o(capb_val), .aux_cap_o(auxc),
    .aux_cap_val_o(aux_val), .aux_cnt_o(aux_cnt), .flags_o(flags)
  );

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      if (n_fail < 25) $display("FAIL %s actual=%0h expected=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  // cycle model built from the requirements
  logic [15:0] m_lo, m_hi, m_locmp, m_hicmp, m_aux, m_capb, m_t2d;
  logic [63:0] m_auxv;
  logic [5:0]  m_ctrl, m_psc, mask;
  logic [2:0]  m_t2a;
  logic        m_t2v, m_lom, m_him, m_cb, m_ac;
  logic [3:0]  m_fl;
  logic        tick, lw, hw, lwrap, lme, clr, hclk, hme, cbe, ace;
  logic [15:0] lstep, hstep, hval;

  function automatic logic [5:0] psc_mask(input logic [1:0] s);
    return 6'((32'd1 << (2 * s)) - 32'd1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo <= '0; m_hi <= '0; m_locmp <= 16'hFFFF; m_hicmp <= 16'hFFFF;
      m_aux <= '0; m_capb <= '0; m_auxv <= '0; m_ctrl <= '0; m_psc <= '0;
      m_t2v <= 1'b0; m_t2a <= '0; m_t2d <= '0;
      m_lom <= 1'b0; m_him <= 1'b0; m_cb <= 1'b0; m_ac <= 1'b0; m_fl <= '0;
    end else begin
      mask  = psc_mask(m_ctrl[2:1]);
      tick  = m_ctrl[0] && ((m_psc & mask) == mask);
      lw    = m_t2v && m_t2a == 3'd0;
      hw    = m_t2v && m_t2a == 3'd1;
      lstep = lo_down ? m_lo - 16'd1 : m_lo + 16'd1;
      lwrap = tick && (lo_down ? m_lo == 16'h0 : m_lo == 16'hFFFF);
      lme   = tick && !lw && lstep == m_locmp;
      clr   = m_ctrl[5] && lme;
      hclk  = lwrap && !lw;
      hstep = hi_down ? m_hi - 16'd1 : m_hi + 16'd1;
      hval  = hw ? m_t2d : (hclk ? hstep : m_hi);
      hme   = lwrap && !hw && hval == m_hicmp;
      cbe   = m_ctrl[4] && hme;
      ace   = m_ctrl[3] && hclk;
      m_lo  <= lw ? m_t2d : (clr ? 16'h0 : (tick ? lstep : m_lo));
      m_hi  <= hw ? m_t2d : (clr ? 16'h0 : hval);
      if (m_t2v && m_t2a == 3'd2) m_locmp <= m_t2d;
      if (m_t2v && m_t2a == 3'd3) m_hicmp <= m_t2d;
      if (m_t2v && m_t2a == 3'd4) m_ctrl <= m_t2d[5:0];
      m_fl  <= (m_fl & ~((m_t2v && m_t2a == 3'd5) ? m_t2d[3:0] : 4'h0)) | {ace, cbe, hme, lme};
      if (ace) m_auxv <= {4{m_aux}};
      if (cbe) m_capb <= m_aux;
      m_lom <= lme; m_him <= hme; m_cb <= cbe; m_ac <= ace;
      m_aux <= m_aux + 16'd1;
      m_psc <= m_psc + 6'd1;
      m_t2v <= req; m_t2a <= addr; m_t2d <= wdata;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(lo_cnt == m_lo, "R2 lower count", lo_cnt, m_lo);
      chk(hi_cnt == m_hi, "R3 upper count", hi_cnt, m_hi);
      chk(lo_m == m_lom, "R5 lower match", lo_m, m_lom);
      chk(hi_m == m_him, "R5 upper match", hi_m, m_him);
      chk(capb == m_cb && capb_val == m_capb, "R7 capture B", {capb, capb_val}, {m_cb, m_capb});
      chk(auxc == m_ac && aux_val == m_auxv, "R6 aux capture", aux_val, m_auxv);
      chk(flags == m_fl, "R9 flags", flags, m_fl);
      chk(aux_cnt == m_aux, "R6 timestamp", aux_cnt, m_aux);
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    req = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  function automatic logic [15:0] pick_data();
    case ($urandom % 5)
      0: return 16'hFFFF;
      1: return 16'hFFFE;
      2: return 16'h0000;
      3: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  // tgt: 0 no write, 1 lower write on the wrap cycle, 2 upper write on the wrap cycle
  task automatic contend(input bit down, input int tgt, input logic [15:0] wv,
                         input logic [15:0] hinit, input logic [15:0] hcmp);
    logic [15:0] e_lo, e_hi;
    logic        e_hm;
    bus_wr(3'd4, 16'h0);
    bus_wr(3'd0, down ? 16'h0001 : 16'hFFFE);
    bus_wr(3'd1, hinit);
    bus_wr(3'd3, hcmp);
    bus_wr(3'd5, 16'hF);
    lo_down = down; hi_down = down;
    @(negedge clk);
    bus_wr(3'd4, 16'h0019);               // run, /1, aux and capture-B enabled
    @(negedge clk);
    if (tgt == 1)      bus_wr(3'd0, wv);   // commits on the wrap edge
    else if (tgt == 2) bus_wr(3'd1, wv);
    else               @(negedge clk);
    @(negedge clk);
    e_lo = (tgt == 1) ? wv : (down ? 16'hFFFF : 16'h0000);
    e_hi = (tgt == 2) ? wv : ((tgt == 1) ? hinit : (down ? hinit - 16'd1 : hinit + 16'd1));
    e_hm = (tgt != 2) && (e_hi == hcmp);
    chk(lo_cnt == e_lo, (tgt == 1) ? "R4 write wins over wrap" : "R2 wrap value", lo_cnt, e_lo);
    chk(hi_cnt == e_hi, (tgt == 1) ? "R4 upper held" : ((tgt == 2) ? "R10 upper write wins" : "R3 upper step"), hi_cnt, e_hi);
    chk(hi_m == e_hm, "R5 match on held value", hi_m, e_hm);
    chk(auxc == (tgt != 1), "R6 no capture on dropped carry", auxc, tgt != 1);
    chk(capb == e_hm, "R7 capture B with match", capb, e_hm);
  endtask

  initial begin
    void'($urandom(32'h0C0FFEE5));
    repeat (3) @(negedge clk);
    chk(lo_cnt == 0 && hi_cnt == 0 && flags == 0, "R11 reset counters", {lo_cnt, hi_cnt}, 0);
    chk(!lo_m && !hi_m && !capb && !auxc && aux_val == 0, "R11 reset pulses", {lo_m, hi_m, capb, auxc}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_en = 1'b1;

    // R1: commit timing with the counter stopped
    bus_wr(3'd0, 16'hABCD);
    chk(lo_cnt == 16'h0000, "R1 not yet committed", lo_cnt, 0);
    @(negedge clk);
    chk(lo_cnt == 16'hABCD, "R1 committed after T2", lo_cnt, 16'hABCD);
    bus_wr(3'd6, 16'h1111);
    @(negedge clk);
    chk(lo_cnt == 16'hABCD, "R1 unused address ignored", lo_cnt, 16'hABCD);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 60 == 0) lo_down = ~lo_down;
      if ($urandom % 80 == 0) hi_down = ~hi_down;
      if ($urandom % 3 == 0) begin
        logic [2:0] a;
        a = 3'($urandom % 6);
        if (a == 3'd4) bus_wr(a, {10'h0, 6'($urandom) | 6'h01} & ((($urandom % 3) != 0) ? 16'hFFF9 : 16'hFFFF));
        else           bus_wr(a, pick_data());
      end else begin
        @(negedge clk);
      end
    end

    // directed contention and its neighbours
    contend(1'b0, 1, 16'hFFFF, 16'h0005, 16'h0005);
    contend(1'b0, 1, 16'h1234, 16'h0005, 16'h0006);
    contend(1'b0, 0, 16'h0000, 16'h0005, 16'h0006);
    contend(1'b1, 1, 16'h00AA, 16'h0010, 16'h0010);
    contend(1'b1, 0, 16'h0000, 16'h0010, 16'h000F);
    contend(1'b0, 2, 16'h7777, 16'h0005, 16'h0006);

    // R8: shared clear on lower match
    bus_wr(3'd4, 16'h0);
    bus_wr(3'd0, 16'h0000);
    bus_wr(3'd1, 16'h0007);
    bus_wr(3'd2, 16'h0003);
    lo_down = 1'b0; hi_down = 1'b0;
    bus_wr(3'd4, 16'h0021);
    repeat (4) @(negedge clk);
    chk(lo_cnt == 0 && hi_cnt == 0, "R8 both counters cleared", {lo_cnt, hi_cnt}, 0);
    chk(lo_m == 1'b1, "R8 clear comes with lower match", lo_m, 1);

    // R9: flag clear with no events pending
    bus_wr(3'd4, 16'h0);
    bus_wr(3'd5, 16'h000F);
    @(negedge clk);
    chk(flags == 4'h0, "R9 flags cleared by write", flags, 0);

    // R2: prescale /4 steps once in four cycles
    bus_wr(3'd0, 16'h0100);
    bus_wr(3'd4, 16'h0003);
    repeat (16) @(negedge clk);
    chk(lo_cnt >= 16'h0103 && lo_cnt <= 16'h0105, "R2 prescale by 4", lo_cnt, 16'h0104);

    repeat (4) @(negedge clk);
    cmp_en = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R11 watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule